// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Access Router

This block sits behind the programmed-I/O decoder of a dual-channel legacy disk controller. Each access arrives with a region index (0 to 4), a byte offset inside that region, a size in bytes, a direction and write data. The router checks that the access is legal and picks its target: the command or control port of one of the two channels, or one of the two bus-master register windows. It rewrites the offset where the target expects a different one and issues a single-cycle request on the matching downstream port. Read data from that port comes back the same cycle and is returned on a registered response one cycle after the access.

For each channel the router remembers which of the two attached devices is currently addressed. It learns this by watching writes to the drive/head register. Accesses to a device slot that is empty are answered with zero and never reach the device side. Writes to the bus-master windows are only let through while the bus-master enable from the PCI command register is set. An interrupt-post event produces one-cycle pulses that set the primary channel's bus-master interrupt status and raise the interrupt line.

Top module: `dskio_router`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes, whose region index is above 4, or whose region-4 offset is 16 or more is rejected. Its response carries `rsp_error`=1 and `rsp_rdata`=0. No downstream request is issued and the device selection does not change.
- R2: Region 0 goes to the channel-0 command port and region 1 to the channel-0 control port. Region 2 goes to the channel-1 command port and region 3 to the channel-1 control port. On the device port, `dev_req_ctrl`=0 means command and 1 means control, and `dev_req_ch` gives the channel.
- R3: For region 0 the forwarded offset is the access offset shifted right by `IO_SHIFT` (default 2). For region 1 it is the access offset plus `CTRL_ADD` (default 2). Regions 2 and 3 forward the offset unchanged.
- R4: A legal write to a command port whose forwarded offset equals 6 selects device 1 of that channel when write-data bit 4 is 1, and device 0 otherwise. The new selection already applies to that same write.
- R5: After reset both channels have device 0 selected, and no response or downstream request is active.
- R6: When the selected slot of the addressed channel is empty (`dev_present` bit index = channel*2 + device is 0), a command or control access is not forwarded. Its response has `rsp_error`=0 and `rsp_rdata`=0.
- R7: A region-4 write made while `bm_enable` is 0 is not forwarded and receives a normal response with zero data. Region-4 reads are forwarded regardless of `bm_enable`.
- R8: Region-4 offsets 0 to 7 go to the channel-0 bus-master window with the offset unchanged. Offsets 8 to 15 go to the channel-1 window with 8 subtracted.
- R9: Every access cycle (`req_valid`=1) yields exactly one response on the next cycle, in order. A forwarded read returns the downstream read data sampled in the access cycle. Writes return zero.
- R10: The cycle after `intr_post` is 1, both `bmi_int_set` and `irq` are 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_bar | input | 3 | Region index |
| req_off | input | OFF_W | Byte offset inside the region |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| bm_enable | input | 1 | Bus-master enable from the PCI command register |
| dev_present | input | 4 | Slot occupied, index channel*2 + device |
| intr_post | input | 1 | Interrupt-post event |
| rsp_valid | output | 1 | Response valid |
| rsp_error | output | 1 | Access was rejected |
| rsp_rdata | output | DATA_W | Read data |
| dev_req_valid | output | 1 | Device port request |
| dev_req_ch | output | 1 | Channel |
| dev_req_dev | output | 1 | Selected device |
| dev_req_ctrl | output | 1 | 0 = command port, 1 = control port |
| dev_req_off | output | OFF_W | Forwarded offset |
| dev_req_size | output | 3 | Size in bytes |
| dev_req_write | output | 1 | Direction |
| dev_req_wdata | output | DATA_W | Write data |
| dev_rdata | input | DATA_W | Device read data, same cycle |
| bm_req_valid | output | 1 | Bus-master window request |
| bm_req_ch | output | 1 | Window channel |
| bm_req_off | output | OFF_W | Offset inside the window |
| bm_req_size | output | 3 | Size in bytes |
| bm_req_write | output | 1 | Direction |
| bm_req_wdata | output | DATA_W | Write data |
| bm_rdata | input | DATA_W | Window read data, same cycle |
| bmi_int_set | output | 1 | Pulse that sets primary bus-master interrupt status |
| irq | output | 1 | Interrupt pulse |

## Verification
Downstream requests are combinational in the access cycle. The bench drives each access on a falling edge and checks the device and bus-master ports one nanosecond later, inside the same cycle. Responses are due one rising edge after the access. The driver pushes the expected error flag and data into a queue, and a monitor pops and compares them on the next falling edge, so back-to-back accesses and stray responses are both caught. The interrupt pulses are due one edge after `intr_post` and are checked on the following falling edge, and again one cycle later to confirm they are gone.

// File: rtl/dskio_pkg.sv
`timescale 1ns/1ps
package dskio_pkg;
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CMD  = 2'd1,
      TGT_CTRL = 2'd2,
      TGT_BM   = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e tgt;
      logic ch;
      logic err;
   } route_t;
endpackage

// File: rtl/dskio_decode.sv
`timescale 1ns/1ps
module dskio_decode
   import dskio_pkg::*;
#(
   parameter int OFF_W    = 8,
   parameter int IO_SHIFT = 2,
   parameter int CTRL_ADD = 2,
   parameter int BM_WIN   = 8
) (
   input  logic [2:0]       bar,
   input  logic [OFF_W-1:0] off,
   input  logic [2:0]       size,
   output route_t           rt,
   output logic [OFF_W-1:0] eoff
);
   localparam logic [OFF_W-1:0] WIN_LO = OFF_W'(BM_WIN);
   localparam logic [OFF_W-1:0] WIN_HI = OFF_W'(2 * BM_WIN);
   localparam logic [OFF_W-1:0] CADD   = OFF_W'(CTRL_ADD);

   logic [OFF_W-1:0] off_sh;
   logic             size_ok;

   generate
      if (IO_SHIFT == 0) begin : g_noshift
         assign off_sh = off;
      end else begin : g_shift
         assign off_sh = off >> IO_SHIFT;
      end
   endgenerate

   assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

   always_comb begin
      rt.tgt = TGT_NONE;
      rt.ch  = 1'b0;
      rt.err = 1'b0;
      eoff   = off;
      case (bar)
         3'd0: begin
            rt.tgt = TGT_CMD;
            eoff   = off_sh;
         end
         3'd1: begin
            rt.tgt = TGT_CTRL;
            eoff   = off + CADD;
         end
         3'd2: begin
            rt.tgt = TGT_CMD;
            rt.ch  = 1'b1;
         end
         3'd3: begin
            rt.tgt = TGT_CTRL;
            rt.ch  = 1'b1;
         end
         3'd4: begin
            if (off < WIN_LO) begin
               rt.tgt = TGT_BM;
            end else if (off < WIN_HI) begin
               rt.tgt = TGT_BM;
               rt.ch  = 1'b1;
               eoff   = off - WIN_LO;
            end else begin
               rt.err = 1'b1;
            end
         end
         default: rt.err = 1'b1;
      endcase
      if (!size_ok) rt.err = 1'b1;
      if (rt.err) rt.tgt = TGT_NONE;
   end
endmodule

// File: rtl/dskio_select.sv
`timescale 1ns/1ps
module dskio_select #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd,
   input  logic           upd_ch,
   input  logic           upd_dev,
   output logic [NCH-1:0] sel_q
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n)
               sel_q[c] <= 1'b0;
            else if (upd && (int'(upd_ch) == c))
               sel_q[c] <= upd_dev;
         end
      end
   endgenerate
endmodule

// File: rtl/dskio_resp.sv
`timescale 1ns/1ps
module dskio_resp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              err,
   input  logic [DATA_W-1:0] rdata_nx,
   input  logic              intr_post,
   output logic              rsp_valid,
   output logic              rsp_error,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bmi_int_set,
   output logic              irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_error   <= 1'b0;
         rsp_rdata   <= '0;
         bmi_int_set <= 1'b0;
         irq         <= 1'b0;
      end else begin
         rsp_valid   <= acc;
         rsp_error   <= acc && err;
         rsp_rdata   <= acc ? rdata_nx : '0;
         bmi_int_set <= intr_post;
         irq         <= intr_post;
      end
   end
endmodule

// File: rtl/dskio_router.sv
`timescale 1ns/1ps
module dskio_router
   import dskio_pkg::*;
#(
   parameter int OFF_W    = 8,
   parameter int DATA_W   = 32,
   parameter int IO_SHIFT = 2,
   parameter int CTRL_ADD = 2,
   parameter int BM_WIN   = 8,
   parameter int SEL_OFF  = 6,
   parameter int SEL_BIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_bar,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [2:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bm_enable,
   input  logic [3:0]        dev_present,
   input  logic              intr_post,
   output logic              rsp_valid,
   output logic              rsp_error,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              dev_req_valid,
   output logic              dev_req_ch,
   output logic              dev_req_dev,
   output logic              dev_req_ctrl,
   output logic [OFF_W-1:0]  dev_req_off,
   output logic [2:0]        dev_req_size,
   output logic              dev_req_write,
   output logic [DATA_W-1:0] dev_req_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              bm_req_valid,
   output logic              bm_req_ch,
   output logic [OFF_W-1:0]  bm_req_off,
   output logic [2:0]        bm_req_size,
   output logic              bm_req_write,
   output logic [DATA_W-1:0] bm_req_wdata,
   input  logic [DATA_W-1:0] bm_rdata,
   output logic              bmi_int_set,
   output logic              irq
);
   localparam int NCH = 2;
   localparam logic [OFF_W-1:0] SEL_O = OFF_W'(SEL_OFF);

   generate
      if (DATA_W < 32) begin : g_bad_data
         $error("dskio_router: DATA_W must hold a 4-byte access");
      end
      if (IO_SHIFT >= OFF_W) begin : g_bad_shift
         $error("dskio_router: IO_SHIFT must be below OFF_W");
      end
      if (2 * BM_WIN >= (1 << OFF_W)) begin : g_bad_win
         $error("dskio_router: two bus-master windows must fit the offset");
      end
      if (SEL_BIT >= DATA_W) begin : g_bad_sel
         $error("dskio_router: SEL_BIT outside write data");
      end
   endgenerate

   route_t           rt;
   logic [OFF_W-1:0] eoff;
   logic [NCH-1:0]   sel_q;
   logic             sel_hit;
   logic             cur_dev;
   logic             slot_ok;
   logic             to_dev;
   logic             to_bm;
   logic [DATA_W-1:0] rdata_nx;

   dskio_decode #(
      .OFF_W   (OFF_W),
      .IO_SHIFT(IO_SHIFT),
      .CTRL_ADD(CTRL_ADD),
      .BM_WIN  (BM_WIN)
   ) u_decode (
      .bar (req_bar),
      .off (req_off),
      .size(req_size),
      .rt  (rt),
      .eoff(eoff)
   );

   assign sel_hit = req_valid && req_write && (rt.tgt == TGT_CMD) && (eoff == SEL_O);
   assign cur_dev = sel_hit ? req_wdata[SEL_BIT] : sel_q[rt.ch];
   assign slot_ok = dev_present[{rt.ch, cur_dev}];

   dskio_select #(.NCH(NCH)) u_select (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (sel_hit),
      .upd_ch (rt.ch),
      .upd_dev(req_wdata[SEL_BIT]),
      .sel_q  (sel_q)
   );

   assign to_dev = req_valid && ((rt.tgt == TGT_CMD) || (rt.tgt == TGT_CTRL)) && slot_ok;
   assign to_bm  = req_valid && (rt.tgt == TGT_BM) && (!req_write || bm_enable);

   assign dev_req_valid = to_dev;
   assign dev_req_ch    = rt.ch;
   assign dev_req_dev   = cur_dev;
   assign dev_req_ctrl  = (rt.tgt == TGT_CTRL);
   assign dev_req_off   = eoff;
   assign dev_req_size  = req_size;
   assign dev_req_write = req_write;
   assign dev_req_wdata = req_wdata;

   assign bm_req_valid  = to_bm;
   assign bm_req_ch     = rt.ch;
   assign bm_req_off    = eoff;
   assign bm_req_size   = req_size;
   assign bm_req_write  = req_write;
   assign bm_req_wdata  = req_wdata;

   always_comb begin
      rdata_nx = '0;
      if (!req_write) begin
         if (to_dev)     rdata_nx = dev_rdata;
         else if (to_bm) rdata_nx = bm_rdata;
      end
   end

   dskio_resp #(.DATA_W(DATA_W)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (req_valid),
      .err        (rt.err),
      .rdata_nx   (rdata_nx),
      .intr_post  (intr_post),
      .rsp_valid  (rsp_valid),
      .rsp_error  (rsp_error),
      .rsp_rdata  (rsp_rdata),
      .bmi_int_set(bmi_int_set),
      .irq        (irq)
   );
endmodule

// File: rtl/dskio_router_chk.sv
`timescale 1ns/1ps
module dskio_router_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_size,
   input logic              bm_enable,
   input logic [3:0]        dev_present,
   input logic              intr_post,
   input logic              rsp_valid,
   input logic              rsp_error,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              dev_req_valid,
   input logic              dev_req_ch,
   input logic              dev_req_dev,
   input logic              bm_req_valid,
   input logic              bm_req_write,
   input logic              bmi_int_set,
   input logic              irq
);
   // R9
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R9
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1
   bad_size_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4))
      |-> (!dev_req_valid && !bm_req_valid));
   // R1
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> (rsp_valid && rsp_rdata == '0));
   // R6
   empty_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req_valid |-> dev_present[{dev_req_ch, dev_req_dev}]);
   // R7
   bm_write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_req_valid && bm_req_write) |-> bm_enable);
   // R2
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_req_valid, bm_req_valid}));
   // R10
   intr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intr_post |=> (bmi_int_set && irq));
endmodule

bind dskio_router dskio_router_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_size     (req_size),
   .bm_enable    (bm_enable),
   .dev_present  (dev_present),
   .intr_post    (intr_post),
   .rsp_valid    (rsp_valid),
   .rsp_error    (rsp_error),
   .rsp_rdata    (rsp_rdata),
   .dev_req_valid(dev_req_valid),
   .dev_req_ch   (dev_req_ch),
   .dev_req_dev  (dev_req_dev),
   .bm_req_valid (bm_req_valid),
   .bm_req_write (bm_req_write),
   .bmi_int_set  (bmi_int_set),
   .irq          (irq)
);

// File: tb/test_dskio_router.sv
`timescale 1ns/1ps
module test_dskio_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_bar = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        bm_enable = 1'b1;
   logic [3:0]  dev_present = 4'b0111;
   logic        intr_post = 1'b0;
   logic        rsp_valid, rsp_error;
   logic [31:0] rsp_rdata;
   logic        dev_req_valid, dev_req_ch, dev_req_dev, dev_req_ctrl, dev_req_write;
   logic [7:0]  dev_req_off;
   logic [2:0]  dev_req_size;
   logic [31:0] dev_req_wdata, dev_rdata;
   logic        bm_req_valid, bm_req_ch, bm_req_write;
   logic [7:0]  bm_req_off;
   logic [2:0]  bm_req_size;
   logic [31:0] bm_req_wdata, bm_rdata;
   logic        bmi_int_set, irq;

   int checks = 0;
   int errors = 0;
   logic [32:0] exp_q[$];
   logic        msel[2];
   logic        running = 1'b1;

   always #2.5 clk = ~clk;

   // simple device and window models answering in the same cycle
   assign dev_rdata = {16'hC0DE, dev_req_ch, dev_req_dev, dev_req_ctrl, 5'b0, dev_req_off};
   assign bm_rdata  = {16'hB00B, 7'b0, bm_req_ch, bm_req_off};

   dskio_router i_dskio_router (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bar(req_bar),
      .req_off(req_off), .req_size(req_size), .req_write(req_write),
      .req_wdata(req_wdata), .bm_enable(bm_enable), .dev_present(dev_present),
      .intr_post(intr_post), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
      .rsp_rdata(rsp_rdata), .dev_req_valid(dev_req_valid), .dev_req_ch(dev_req_ch),
      .dev_req_dev(dev_req_dev), .dev_req_ctrl(dev_req_ctrl), .dev_req_off(dev_req_off),
      .dev_req_size(dev_req_size), .dev_req_write(dev_req_write),
      .dev_req_wdata(dev_req_wdata), .dev_rdata(dev_rdata), .bm_req_valid(bm_req_valid),
      .bm_req_ch(bm_req_ch), .bm_req_off(bm_req_off), .bm_req_size(bm_req_size),
      .bm_req_write(bm_req_write), .bm_req_wdata(bm_req_wdata), .bm_rdata(bm_rdata),
      .bmi_int_set(bmi_int_set), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: one access per call, back-to-back when called in sequence
   task automatic access(input logic [2:0] bar, input logic [7:0] off, input logic [2:0] size,
                         input logic wr, input logic [31:0] wd, input string req);
      logic err, ch, dev, ctrl, fdev, fbm;
      logic [7:0]  eoff;
      logic [31:0] erd;
      err  = !(size == 3'd1 || size == 3'd2 || size == 3'd4) || (bar > 3'd4) ||
             (bar == 3'd4 && off >= 8'd16);
      ch = 1'b0; dev = 1'b0; ctrl = 1'b0; fdev = 1'b0; fbm = 1'b0; eoff = off; erd = '0;
      if (!err && bar < 3'd4) begin
         ch   = bar[1];
         ctrl = bar[0];
         eoff = (bar == 3'd0) ? (off >> 2) : (bar == 3'd1) ? off + 8'd2 : off;
         if (wr && !ctrl && eoff == 8'd6) msel[ch] = wd[4];
         dev  = msel[ch];
         fdev = dev_present[{ch, dev}];
         if (fdev && !wr) erd = {16'hC0DE, ch, dev, ctrl, 5'b0, eoff};
      end else if (!err) begin
         ch   = (off >= 8'd8);
         eoff = ch ? off - 8'd8 : off;
         fbm  = !wr || bm_enable;
         if (fbm && !wr) erd = {16'hB00B, 7'b0, ch, eoff};
      end
      req_bar = bar; req_off = off; req_size = size; req_write = wr; req_wdata = wd;
      req_valid = 1'b1;
      #1;
      check(req, {62'd0, dev_req_valid, bm_req_valid}, {62'd0, fdev, fbm});
      if (fdev)
         check(req, {dev_req_ch, dev_req_dev, dev_req_ctrl, dev_req_off, dev_req_size,
                     dev_req_write, dev_req_wdata},
                    {ch, dev, ctrl, eoff, size, wr, wd});
      if (fbm)
         check(req, {bm_req_ch, bm_req_off, bm_req_size, bm_req_write, bm_req_wdata},
                    {ch, eoff, size, wr, wd});
      exp_q.push_back({err, erd});
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: responses are due one edge after each access (R9)
   always @(negedge clk) begin
      if (rst_n && running && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check("R9", 64'd1, 64'd0);
         end else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            check("R9", {31'd0, rsp_error, rsp_rdata}, {31'd0, e});
         end
      end
   end

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      msel[0] = 1'b0;
      msel[1] = 1'b0;
      repeat (3) @(negedge clk);
      // R5: idle outputs during reset
      check("R5", {61'd0, rsp_valid, dev_req_valid, bm_req_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5", {62'd0, rsp_valid, irq}, 64'd0);

      // R2 R3 R5: routing, offsets, reset selection of device 0
      access(3'd0, 8'd8, 3'd1, 1'b0, 32'h0, "R5");
      access(3'd1, 8'd1, 3'd1, 1'b0, 32'h0, "R3");
      access(3'd2, 8'd5, 3'd2, 1'b0, 32'h0, "R2");
      access(3'd3, 8'd2, 3'd4, 1'b0, 32'h0, "R2");
      // R4: shifted offset 24 -> 6 selects device 1 on channel 0
      access(3'd0, 8'd24, 3'd1, 1'b1, 32'h0000_0010, "R4");
      access(3'd0, 8'd4, 3'd1, 1'b0, 32'h0, "R4");
      // R3: control offset 4 + 2 = 6 is not a select
      access(3'd1, 8'd4, 3'd1, 1'b1, 32'h0000_0000, "R3");
      access(3'd0, 8'd0, 3'd2, 1'b0, 32'h0, "R3");
      // R6: channel 1 device 1 slot is empty
      access(3'd2, 8'd6, 3'd1, 1'b1, 32'h0000_00F0, "R6");
      access(3'd2, 8'd0, 3'd1, 1'b0, 32'h0, "R6");
      access(3'd3, 8'd1, 3'd1, 1'b1, 32'h0000_0055, "R6");
      access(3'd3, 8'd1, 3'd1, 1'b0, 32'h0, "R6");
      // R4: bit 4 clear returns channel 1 to device 0
      access(3'd2, 8'd6, 3'd1, 1'b1, 32'h0000_00EF, "R4");
      access(3'd2, 8'd3, 3'd1, 1'b0, 32'h0, "R4");
      // R1: illegal sizes, region and window range
      access(3'd0, 8'd24, 3'd3, 1'b1, 32'h0000_0000, "R1");
      access(3'd0, 8'd4, 3'd1, 1'b0, 32'h0, "R1");
      access(3'd2, 8'd0, 3'd0, 1'b0, 32'h0, "R1");
      access(3'd2, 8'd0, 3'd7, 1'b0, 32'h0, "R1");
      access(3'd5, 8'd0, 3'd1, 1'b0, 32'h0, "R1");
      access(3'd4, 8'd16, 3'd1, 1'b0, 32'h0, "R1");
      // R8: window split
      access(3'd4, 8'd3, 3'd1, 1'b0, 32'h0, "R8");
      access(3'd4, 8'd12, 3'd4, 1'b0, 32'h0, "R8");
      access(3'd4, 8'd15, 3'd1, 1'b1, 32'h0000_0004, "R8");
      // R7: gated writes, ungated reads
      bm_enable = 1'b0;
      access(3'd4, 8'd2, 3'd1, 1'b1, 32'h0000_0006, "R7");
      access(3'd4, 8'd10, 3'd1, 1'b1, 32'h0000_0001, "R7");
      access(3'd4, 8'd9, 3'd1, 1'b0, 32'h0, "R7");
      bm_enable = 1'b1;
      access(3'd4, 8'd0, 3'd1, 1'b1, 32'h0000_0001, "R7");

      repeat (2) @(negedge clk);
      check("R9", {32'd0, exp_q.size()}, 64'd0);

      // R10: interrupt post pulses
      intr_post = 1'b1;
      @(negedge clk);
      intr_post = 1'b0;
      check("R10", {62'd0, bmi_int_set, irq}, 64'd3);
      @(negedge clk);
      check("R10", {62'd0, bmi_int_set, irq}, 64'd0);

      running = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule